// File: doc/BRIEF.md
# Serial EEPROM Slave Model (512 bytes, SPI mode 0)

This block behaves as a small serial EEPROM attached to an SPI bus. It holds a 512-byte array and a status register. The host talks to it in SPI mode 0. SCLK idles low, the slave samples MOSI on each rising SCLK edge, and it changes MISO after each falling edge, most significant bit first. Every transaction starts with a command byte. Memory commands then carry one address byte. The ninth address bit is not sent as a separate byte: it travels in bit 3 of the command byte.

The bus pins are oversampled by the system clock through synchronizers. Reads stream bytes from consecutive addresses for as long as SCLK runs, and wrap from the top of the array to address 0. Writes need the write enable latch to be set. They collect bytes into an 8-byte page buffer, and the buffer goes into the array only when chip select rises on a byte boundary. After that the block reports busy for a fixed number of system clocks, and the latch clears when busy ends. A status write also passes through this commit and busy sequence. Protection bits can lock the top of the array, and a pin-enable bit lets the write-protect input freeze the status register.

Top module: `eeprom_spi_slave`

## Requirements
- R1: Timing follows SPI mode 0: MOSI is sampled on rising SCLK edges and MISO changes only after falling SCLK edges, MSB first. The first data bit of a read is valid before the first rising edge of that data byte.
- R2: Opcodes are matched with command bit 3 masked off: 0x01 status write, 0x02 memory write, 0x03 memory read, 0x04 latch clear, 0x05 status read, 0x06 latch set. For the read and write opcodes, command bit 3 supplies address bit 8.
- R3: A read returns bytes from consecutive addresses, starting at the given address, and wraps from address 511 to address 0.
- R4: A memory write or status write issued while the latch (status bit 1) is clear has no effect on the array or on the status register.
- R5: Write data fills the 8-byte page that holds the start address. After offset 7 it wraps to offset 0 of the same page. Bytes of the page that were not sent keep their old contents.
- R6: A write or status write takes effect only when chip select rises on a byte boundary after at least one data byte. If chip select rises in the middle of a byte, the command is aborted: nothing is written, busy does not start, and the latch is unchanged.
- R7: A commit sets the busy flag (status bit 0) for WRITE_CYCLES system clocks. The latch clears when busy ends.
- R8: While busy, only the status read command is accepted. Every other command, including latch set, latch clear and status write, is ignored.
- R9: The status byte reads as: bit 7 pin enable, bits 4:2 protection level, bit 1 latch, bit 0 busy, bits 6:5 zero. A status write stores only bits 7 and 4:2.
- R10: A protection level n other than 0 protects the top PAGE_BYTES·2^n bytes of the array. A write whose address byte falls in that region is ignored, does not start busy, and leaves the latch set.
- R11: While the pin-enable bit is 1 and the write-protect input is low, status writes are ignored.
- R12: MISO is driven low while chip select is deasserted and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| wpN | input | 1 | Active-low write-protect input |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions assume that each SCLK level and each chip-select level lasts several system clocks, so every bus edge is seen once through the synchronizers. They also assume that MOSI is stable around the rising SCLK edge and that chip select changes only while SCLK is low. The stimulus meets these assumptions by holding each SCLK phase for six system clocks. It sets MOSI and moves chip select only while SCLK is low, and it keeps a gap of several half-periods around every chip-select change. Polls during busy are timed to start well inside the busy window, and the bench waits longer than WRITE_CYCLES before checking the state after busy.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W    = 9;
  localparam int MEM_BYTES = 1 << ADDR_W;

  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;
  localparam logic [7:0] OP_MEM_RD    = 8'h03;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_MASK      = 8'hF7;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RDMEM, ST_WRMEM, ST_RDSTAT, ST_WRSTAT, ST_SKIP
  } eepState_t;

  typedef struct packed {
    logic takeHiBit;
    logic loadAddr;
    logic txFromMem;
    logic txFromStatus;
    logic bufClear;
    logic bufCapture;
    logic pageCommit;
    logic statusHold;
    logic statusCommit;
    logic latchSet;
    logic latchClr;
  } eepStrobes_t;
endpackage

// File: rtl/eep_spi_rx.sv
module eep_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       csHigh,
  output logic       csRise,
  output logic       sclkFall,
  output logic       byteValid,
  output logic       atBoundary,
  output logic [7:0] rxByte
);
  logic [SYNC_STAGES-1:0] sclkPipe, csPipe, mosiPipe;
  logic       sclkPrev, csPrev, sclkS, mosiS, sclkRise;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;

  assign sclkS      = sclkPipe[SYNC_STAGES-1];
  assign mosiS      = mosiPipe[SYNC_STAGES-1];
  assign csHigh     = csPipe[SYNC_STAGES-1];
  assign sclkRise   = sclkS & ~sclkPrev & ~csHigh;
  assign sclkFall   = ~sclkS & sclkPrev & ~csHigh;
  assign csRise     = csHigh & ~csPrev;
  assign atBoundary = (bitCnt == 3'd0);
  assign byteValid  = sclkRise && (bitCnt == 3'd7);
  assign rxByte     = {shiftIn, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe[0] <= sclk;
      csPipe[0]   <= csN;
      mosiPipe[0] <= mosi;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclkPipe[i] <= sclkPipe[i-1];
        csPipe[i]   <= csPipe[i-1];
        mosiPipe[i] <= mosiPipe[i-1];
      end
      sclkPrev <= sclkS;
      csPrev   <= csHigh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= 3'd0;
      shiftIn <= 7'd0;
    end else if (csHigh) begin
      bitCnt <= 3'd0;
    end else if (sclkRise) begin
      bitCnt  <= bitCnt + 3'd1;
      shiftIn <= {shiftIn[5:0], mosiS};
    end
  end

  // R6: a deselect always leaves the bit counter on a byte boundary
  a_r6_boundary_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (bitCnt == 3'd0));
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl import eep_pkg::*; #(
  parameter int WRITE_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csHigh,
  input  logic        csRise,
  input  logic        byteValid,
  input  logic        atBoundary,
  input  logic [7:0]  rxByte,
  input  logic        latchOn,
  input  logic        wpEnable,
  input  logic        wpN,
  input  logic        tgtProtected,
  output eepStrobes_t st,
  output logic        busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

  eepState_t        state, nextState;
  logic             isWrite, dataGot;
  logic [CNT_W-1:0] busyCnt;
  logic [7:0]       opc;
  logic             busyDone, statusLocked;

  assign opc          = rxByte & OP_MASK;
  assign busyDone     = busy && (busyCnt == CNT_LAST);
  assign statusLocked = wpEnable && !wpN;

  always_comb begin
    st        = '0;
    nextState = state;
    if (byteValid) begin
      unique case (state)
        ST_CMD: begin
          nextState = ST_SKIP;
          if (opc == OP_STAT_RD) begin
            st.txFromStatus = 1'b1;
            nextState       = ST_RDSTAT;
          end else if (!busy) begin
            unique case (opc)
              OP_MEM_RD: begin
                st.takeHiBit = 1'b1;
                nextState    = ST_ADDR;
              end
              OP_MEM_WR: if (latchOn) begin
                st.takeHiBit = 1'b1;
                nextState    = ST_ADDR;
              end
              OP_STAT_WR:   if (latchOn && !statusLocked) nextState = ST_WRSTAT;
              OP_LATCH_ON:  st.latchSet = 1'b1;
              OP_LATCH_OFF: st.latchClr = 1'b1;
              default: ;
            endcase
          end
        end
        ST_ADDR: begin
          if (!isWrite) begin
            st.loadAddr  = 1'b1;
            st.txFromMem = 1'b1;
            nextState    = ST_RDMEM;
          end else if (tgtProtected) begin
            nextState = ST_SKIP;
          end else begin
            st.loadAddr = 1'b1;
            st.bufClear = 1'b1;
            nextState   = ST_WRMEM;
          end
        end
        ST_RDMEM:  st.txFromMem    = 1'b1;
        ST_WRMEM:  st.bufCapture   = 1'b1;
        ST_RDSTAT: st.txFromStatus = 1'b1;
        ST_WRSTAT: st.statusHold   = 1'b1;
        default: ;
      endcase
    end
    if (csRise && atBoundary && dataGot) begin
      st.pageCommit   = (state == ST_WRMEM);
      st.statusCommit = (state == ST_WRSTAT);
    end
    if (busyDone) st.latchClr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CMD;
      isWrite <= 1'b0;
      dataGot <= 1'b0;
    end else if (csHigh) begin
      state   <= ST_CMD;
      dataGot <= 1'b0;
    end else begin
      state <= nextState;
      if (byteValid && state == ST_CMD) isWrite <= (opc == OP_MEM_WR);
      if (byteValid && (state == ST_WRMEM || state == ST_WRSTAT)) dataGot <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
    end else if (st.pageCommit || st.statusCommit) begin
      busy    <= 1'b1;
      busyCnt <= '0;
    end else if (busy) begin
      if (busyDone) busy <= 1'b0;
      else          busyCnt <= busyCnt + 1'b1;
    end
  end

  // R4: the write data phase is only ever entered with the latch set
  a_r4_write_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRMEM && $past(state) != ST_WRMEM) |-> latchOn);
  // R7: the latch is clear once the busy period has ended
  a_r7_latch_clear_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !latchOn);
  // R8: a command taken while busy leads only to status read or skip
  a_r8_busy_only_status: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteValid && state == ST_CMD) |=> (state == ST_RDSTAT || state == ST_SKIP));
endmodule

// File: rtl/eep_datapath.sv
module eep_datapath import eep_pkg::*; #(
  parameter int PAGE_BYTES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csHigh,
  input  logic        sclkFall,
  input  logic [7:0]  rxByte,
  input  eepStrobes_t st,
  input  logic        busy,
  output logic        miso,
  output logic        latchOn,
  output logic        wpEnable,
  output logic        tgtProtected
);
  localparam int POFF_W = $clog2(PAGE_BYTES);

  logic [7:0]            mem [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [ADDR_W-1:0]     addrReg, tgtAddr, rdAddr;
  logic [POFF_W-1:0]     pageOff;
  logic                  hiBit, misoReg, latchReg, wpenReg;
  logic [2:0]            bpReg;
  logic [3:0]            statPend;
  logic [7:0]            txShift, statusByte;
  logic [31:0]           region;

  assign tgtAddr    = {hiBit, rxByte};
  assign rdAddr     = st.loadAddr ? tgtAddr : addrReg;
  assign pageOff    = addrReg[POFF_W-1:0];
  assign statusByte = {wpenReg, 2'b00, bpReg, latchReg, busy};
  assign miso       = misoReg;
  assign latchOn    = latchReg;
  assign wpEnable   = wpenReg;

  always_comb begin
    region       = 32'(PAGE_BYTES) << bpReg;
    tgtProtected = (bpReg != 3'd0) && ((32'(tgtAddr) + region) >= 32'(MEM_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else if (st.pageCommit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageMask[i]) mem[{addrReg[ADDR_W-1:POFF_W], POFF_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (st.bufCapture) pageBuf[pageOff] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageMask <= '0;
      addrReg  <= '0;
      hiBit    <= 1'b0;
    end else begin
      if (st.takeHiBit) hiBit <= rxByte[3];
      if (st.bufClear) pageMask <= '0;
      else if (st.bufCapture) pageMask[pageOff] <= 1'b1;
      if (st.loadAddr)
        addrReg <= st.txFromMem ? tgtAddr + ADDR_W'(1) : tgtAddr;
      else if (st.txFromMem)
        addrReg <= addrReg + ADDR_W'(1);
      else if (st.bufCapture)
        addrReg[POFF_W-1:0] <= pageOff + POFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'h00;
      misoReg <= 1'b0;
    end else if (csHigh) begin
      txShift <= 8'h00;
      misoReg <= 1'b0;
    end else if (st.txFromMem) begin
      txShift <= mem[rdAddr];
    end else if (st.txFromStatus) begin
      txShift <= statusByte;
    end else if (sclkFall) begin
      misoReg <= txShift[7];
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= 1'b0;
      wpenReg  <= 1'b0;
      bpReg    <= 3'd0;
      statPend <= 4'd0;
    end else begin
      if (st.latchClr)      latchReg <= 1'b0;
      else if (st.latchSet) latchReg <= 1'b1;
      if (st.statusHold) statPend <= {rxByte[7], rxByte[4:2]};
      if (st.statusCommit) begin
        wpenReg <= statPend[3];
        bpReg   <= statPend[2:0];
      end
    end
  end

  // R3: sequential read past the last address continues at address 0
  a_r3_read_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (st.txFromMem && !st.loadAddr && addrReg == ADDR_W'(MEM_BYTES - 1)) |=> (addrReg == '0));
  // R5: capturing write data never leaves the current page
  a_r5_page_stays: assert property (@(posedge clk) disable iff (!rstN)
    st.bufCapture |=> (addrReg[ADDR_W-1:POFF_W] == $past(addrReg[ADDR_W-1:POFF_W])));
  // R12: output returns low once the slave is deselected
  a_r12_miso_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !misoReg);
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave import eep_pkg::*; #(
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  input  logic wpN,
  output logic miso
);
  logic        csHigh, csRise, sclkFall, byteValid, atBoundary;
  logic [7:0]  rxByte;
  logic        latchOn, wpEnable, tgtProtected, busy;
  eepStrobes_t st;

  eep_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .csHigh(csHigh), .csRise(csRise), .sclkFall(sclkFall),
    .byteValid(byteValid), .atBoundary(atBoundary), .rxByte(rxByte)
  );

  eep_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .csRise(csRise),
    .byteValid(byteValid), .atBoundary(atBoundary), .rxByte(rxByte),
    .latchOn(latchOn), .wpEnable(wpEnable), .wpN(wpN),
    .tgtProtected(tgtProtected), .st(st), .busy(busy)
  );

  eep_datapath #(.PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .sclkFall(sclkFall),
    .rxByte(rxByte), .st(st), .busy(busy), .miso(miso),
    .latchOn(latchOn), .wpEnable(wpEnable), .tgtProtected(tgtProtected)
  );
endmodule

// File: tb/eeprom_spi_slave_tb.sv
module eeprom_spi_slave_tb;
  localparam int WRITE_CYCLES = 200;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0, wpN = 1'b1;
  logic miso;
  int checks = 0, errors = 0;
  logic [7:0] expVal[$];
  string      expTag[$];
  logic [7:0] gotQ[$];
  logic [7:0] model [512];

  always #4 clk = ~clk;

  eeprom_spi_slave #(.WRITE_CYCLES(WRITE_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .wpN(wpN), .miso(miso)
  );

  task automatic xferBits(input logic [7:0] tx, input int nBits, input bit keep);
    logic [7:0] rx = 8'h00;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    if (keep) gotQ.push_back(rx);
  endtask

  task automatic csOn();
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csOff();
    repeat (HALF) @(negedge clk); csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic expectByte(input logic [7:0] v, input string tag);
    expVal.push_back(v); expTag.push_back(tag);
    xferBits(8'h00, 8, 1'b1);
  endtask

  task automatic cmdOnly(input logic [7:0] op);
    csOn(); xferBits(op, 8, 1'b0); csOff();
  endtask

  task automatic readStatus(input logic [7:0] v, input string tag);
    csOn(); xferBits(8'h05, 8, 1'b0); expectByte(v, tag); csOff();
  endtask

  task automatic writeStatus(input logic [7:0] v);
    csOn(); xferBits(8'h01, 8, 1'b0); xferBits(v, 8, 1'b0); csOff();
  endtask

  task automatic waitBusy();
    repeat (WRITE_CYCLES + 40) @(negedge clk);
  endtask

  task automatic memWrite(input logic [8:0] a, input int n, input logic [7:0] d [8], input bit apply);
    csOn();
    xferBits({4'b0000, a[8], 3'b010}, 8, 1'b0);
    xferBits(a[7:0], 8, 1'b0);
    for (int k = 0; k < n; k++) xferBits(d[k], 8, 1'b0);
    csOff();
    if (apply)
      for (int k = 0; k < n; k++) model[{a[8:3], a[2:0] + 3'(k)}] = d[k];
  endtask

  task automatic memRead(input logic [8:0] a, input logic [7:0] op, input int n, input string tag);
    csOn();
    xferBits(op | {4'b0000, a[8], 3'b000}, 8, 1'b0);
    xferBits(a[7:0], 8, 1'b0);
    for (int k = 0; k < n; k++) expectByte(model[9'(a + 9'(k))], tag);
    csOff();
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation for every byte the driver captured
  initial forever begin
    logic [7:0] got, want;
    string tag;
    wait (gotQ.size() > 0);
    got = gotQ.pop_front(); want = expVal.pop_front(); tag = expTag.pop_front();
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, want);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkBit(miso, 1'b0, "R12 miso after reset");
    readStatus(8'h00, "R9 status after reset");

    // write without latch is ignored
    memWrite(9'h010, 1, '{8'hAA, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
    readStatus(8'h00, "R4 no busy after unlatched write");
    memRead(9'h010, 8'h03, 1, "R4 array unchanged");

    cmdOnly(8'h06);
    readStatus(8'h02, "R2 latch set opcode");
    cmdOnly(8'h04);
    readStatus(8'h00, "R2 latch clear opcode");

    // page 0 then upper page with in-page wrap
    cmdOnly(8'h06);
    memWrite(9'h000, 2, '{8'hA5, 8'h5A, 0, 0, 0, 0, 0, 0}, 1'b1);
    waitBusy();
    cmdOnly(8'h06);
    memWrite(9'h1FC, 6, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 0, 0}, 1'b1);
    readStatus(8'h03, "R7 busy and latch during write");
    waitBusy();
    readStatus(8'h00, "R7 latch cleared after busy");
    checkBit(miso, 1'b0, "R12 miso idle after deselect");

    memRead(9'h1F8, 8'h03, 10, "R3 R5 stream with wrap");
    memRead(9'h000, 8'h03, 1, "R1 R2 read low half");

    // abort mid-byte
    cmdOnly(8'h06);
    csOn();
    xferBits(8'h02, 8, 1'b0); xferBits(8'h40, 8, 1'b0); xferBits(8'h77, 8, 1'b0);
    xferBits(8'hFF, 3, 1'b0);
    csOff();
    readStatus(8'h02, "R6 aborted write no busy");
    memRead(9'h040, 8'h03, 1, "R6 aborted write not stored");
    cmdOnly(8'h04);

    // commands during busy are ignored
    cmdOnly(8'h06);
    memWrite(9'h020, 1, '{8'h99, 0, 0, 0, 0, 0, 0, 0}, 1'b1);
    writeStatus(8'h0C);
    waitBusy();
    readStatus(8'h00, "R8 status write ignored while busy");
    memRead(9'h020, 8'h03, 1, "R5 single byte write");

    // block protection
    cmdOnly(8'h06);
    writeStatus(8'h04);
    waitBusy();
    readStatus(8'h04, "R9 protection level stored");
    cmdOnly(8'h06);
    memWrite(9'h1F0, 1, '{8'hEE, 0, 0, 0, 0, 0, 0, 0}, 1'b0);
    readStatus(8'h06, "R10 protected write ignored");
    memWrite(9'h1E8, 1, '{8'hDD, 0, 0, 0, 0, 0, 0, 0}, 1'b1);
    waitBusy();
    memRead(9'h1E8, 8'h03, 1, "R10 unprotected write stored");
    memRead(9'h1F0, 8'h03, 1, "R10 protected byte unchanged");

    // write-protect pin
    cmdOnly(8'h06);
    writeStatus(8'h80);
    waitBusy();
    readStatus(8'h80, "R9 pin enable stored");
    wpN = 1'b0;
    cmdOnly(8'h06);
    writeStatus(8'h00);
    readStatus(8'h82, "R11 status frozen by pin");
    wpN = 1'b1;
    writeStatus(8'h00);
    waitBusy();
    readStatus(8'h00, "R11 status writable with pin high");

    cmdOnly(8'h06);
    writeStatus(8'hFF);
    waitBusy();
    readStatus(8'h9C, "R9 only defined bits stored");

    wait (gotQ.size() == 0);
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule